// File: doc/BRIEF.md
# Quad SPI Flash Read Sequencer

This block runs read transactions against a serial NOR flash. A requester hands it a byte address and a byte count. The sequencer then lowers chip select and clocks out an opcode and the address. If the read mode needs them, it inserts wait clocks. It then collects the requested number of data bytes from the flash and presents each byte on a one-cycle strobe. Each of the three transfer phases (opcode, address, receive) picks one, two or four data lanes on its own.

Serial-clock timing comes from an external half-period enable, `half_tick`. Every change of `sck` and `cs_n` happens in a clock cycle that follows a tick, so one serial clock always spans two ticks. The opcode is selected from the read mode and the address width; two custom modes send a programmed opcode instead. All configuration is latched when a request is accepted. The spacing enforced after chip select releases therefore belongs to the transaction that just ended. The write-protect level is the exception: it is taken live.

Top module: `qspi_read_seq`

## Requirements
- R1: With an address width code of 0, 1 or 2, or with `cfg_wide_op` low, the opcode for read modes 0..5 (0 standard, 1 fast, 2 dual-output, 3 dual-I/O, 4 quad-output, 5 quad-I/O) is 0x03, 0x0B, 0x3B, 0xBB, 0x6B or 0xEB. Modes 6 (custom standard) and 7 (custom fast) send `cfg_custom_op`.
- R2: With address width code 3 and `cfg_wide_op` high, modes 0..5 send 0x13, 0x0C, 0x3C, 0xBC, 0x6C or 0xEC.
- R3: A phase width code of 0 uses one lane (io0 out, io1 in), 1 uses two lanes (io1 carries the more significant bit), and 2 uses four lanes (io3 carries the most significant bit). Code 3 behaves as 0. Bits travel most significant first.
- R4: The address width code A sends A+1 bytes, taken from the low bits of `req_addr`, most significant byte first.
- R5: The wait code W inserts W+3 serial clocks between address and receive. Modes 0 and 6 insert none.
- R6: The receive phase captures lanes on each rising serial clock edge and returns `req_len`+1 bytes, most significant bit first. Each byte is flagged by a single-cycle `rd_valid` pulse.
- R7: The first rising `sck` edge follows the falling `cs_n` by 1 tick, or by 3 ticks when `cfg_setup_long` is set.
- R8: `cs_n` rises 1 tick after the last rising `sck` edge, or 3 ticks after it when `cfg_hold_long` is set.
- R9: After `cs_n` rises, it stays high for at least 2*(G+1) ticks, where G is the gap code; a request already waiting starts exactly then.
- R10: Whenever io2 and io3 carry no data, they are driven with the write-protect level and 1. Whenever chip select is high, io0 is driven low and io1 is released. During wait and receive clocks, io0 and io1 are released, and io2 and io3 are also released when the receive width code is 2.
- R11: After reset, `cs_n` is high and `sck` is low. `sck` is low whenever `cs_n` is high, and `req_ready` is only high while idle in a tick cycle.
- R12: `sck` and `cs_n` change only in the cycle after `half_tick` is high, and one serial clock period is two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Half serial-clock period enable |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Bytes to read minus one |
| cfg_rd_mode | input | 3 | Read mode code |
| cfg_cmd_w | input | 2 | Opcode phase lane width code |
| cfg_adr_w | input | 2 | Address phase lane width code |
| cfg_rx_w | input | 2 | Receive phase lane width code |
| cfg_adr_bytes | input | 2 | Address bytes minus one |
| cfg_wide_op | input | 1 | Use the 4-byte opcode set with 4-byte addresses |
| cfg_custom_op | input | 8 | Opcode for the custom modes |
| cfg_wait | input | 4 | Wait clocks minus three |
| cfg_setup_long | input | 1 | Select-to-clock setup of 3 ticks instead of 1 |
| cfg_hold_long | input | 1 | Clock-to-deselect hold of 3 ticks instead of 1 |
| cfg_gap | input | 4 | Minimum deselect time code |
| cfg_wp_level | input | 1 | Level driven on io2 when it carries no data |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte strobe |

## Verification
The bench runs with a tick every second clock, so each tick is 8 ns and each serial clock is 16 ns. Every header result is due on a known rising `sck` edge. The lane pattern for a given edge is read 1 ns after that edge, and the edges are compared in the order a scoreboard queue predicts them. Setup, hold, gap and serial-clock period are measured as time differences between `cs_n` and `sck` transitions and compared with exact tick multiples. The flash model places each data unit on the lanes before the rising edge on which it is captured. Each byte strobe is compared on the falling clock after it appears, and the model counts the rising edges of every transaction against the total it predicts.

// File: rtl/qsfr_pkg.sv
package qsfr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_SHIFT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADR  = 2'd1,
        PH_WAIT = 2'd2,
        PH_RX   = 2'd3
    } seq_phase_e;

    // width codes: 0 one lane, 1 two lanes, 2 four lanes, 3 one lane
    localparam logic [1:0] W_DUAL = 2'd1;
    localparam logic [1:0] W_QUAD = 2'd2;

    typedef struct packed {
        logic [2:0] rd_mode;
        logic [1:0] cmd_w;
        logic [1:0] adr_w;
        logic [1:0] rx_w;
        logic [1:0] adr_bytes;
        logic       wide_op;
        logic [7:0] custom_op;
        logic [3:0] wait_code;
        logic       setup_long;
        logic       hold_long;
        logic [3:0] gap_code;
    } seq_cfg_t;

endpackage

// File: rtl/qspi_rd_opcode.sv
module qspi_rd_opcode (
    input  logic [2:0] rd_mode,
    input  logic [1:0] adr_bytes,
    input  logic       wide_op,
    input  logic [7:0] custom_op,
    output logic [7:0] opcode
);
    logic use4;

    always_comb begin
        use4 = wide_op && (adr_bytes == 2'd3);
        case (rd_mode)
            3'd0:    opcode = use4 ? 8'h13 : 8'h03;
            3'd1:    opcode = use4 ? 8'h0C : 8'h0B;
            3'd2:    opcode = use4 ? 8'h3C : 8'h3B;
            3'd3:    opcode = use4 ? 8'hBC : 8'hBB;
            3'd4:    opcode = use4 ? 8'h6C : 8'h6B;
            3'd5:    opcode = use4 ? 8'hEC : 8'hEB;
            default: opcode = custom_op;
        endcase
    end
endmodule

// File: rtl/qspi_rd_lanes.sv
module qspi_rd_lanes
    import qsfr_pkg::*;
(
    input  logic       selected,
    input  seq_phase_e ph,
    input  logic [1:0] cmd_w,
    input  logic [1:0] adr_w,
    input  logic [1:0] rx_w,
    input  logic [3:0] tx_top,
    input  logic       wp_level,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    logic [1:0] w;

    always_comb begin
        io_out = {1'b1, wp_level, 2'b00};
        io_oe  = 4'b1101;
        w      = (ph == PH_CMD) ? cmd_w : adr_w;
        if (selected) begin
            if (ph == PH_CMD || ph == PH_ADR) begin
                case (w)
                    W_DUAL: begin
                        io_out = {1'b1, wp_level, tx_top[3:2]};
                        io_oe  = 4'b1111;
                    end
                    W_QUAD: begin
                        io_out = tx_top;
                        io_oe  = 4'b1111;
                    end
                    default: begin
                        io_out = {1'b1, wp_level, 1'b0, tx_top[3]};
                        io_oe  = 4'b1101;
                    end
                endcase
            end else if (rx_w == W_QUAD) begin
                io_out = 4'b0000;
                io_oe  = 4'b0000;
            end else begin
                io_out = {1'b1, wp_level, 2'b00};
                io_oe  = 4'b1100;
            end
        end
    end
endmodule

// File: rtl/qspi_read_seq.sv
module qspi_read_seq
    import qsfr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        cfg_rd_mode,
    input  logic [1:0]        cfg_cmd_w,
    input  logic [1:0]        cfg_adr_w,
    input  logic [1:0]        cfg_rx_w,
    input  logic [1:0]        cfg_adr_bytes,
    input  logic              cfg_wide_op,
    input  logic [7:0]        cfg_custom_op,
    input  logic [3:0]        cfg_wait,
    input  logic              cfg_setup_long,
    input  logic              cfg_hold_long,
    input  logic [3:0]        cfg_gap,
    input  logic              cfg_wp_level,
    output logic              cs_n,
    output logic              sck,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int CLK_W = LEN_W + 4;
    localparam int TX_W  = 32;

    typedef struct packed {
        seq_state_e        st;
        seq_phase_e        ph;
        logic [4:0]        cnt;
        logic [CLK_W-1:0]  left;
        logic              sck;
        logic              csn;
        logic [TX_W-1:0]   tx;
        logic [7:0]        rx;
        logic [2:0]        rxbits;
        logic [7:0]        rdata;
        logic              rvalid;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        seq_cfg_t          cfg;
    } regs_t;

    regs_t    q, d;
    seq_cfg_t cfg_in;
    logic [7:0] opcode;
    logic       rise, fall, has_wait;
    logic [1:0] cur_w;
    logic [3:0] nbits;
    logic [7:0] rx_next;
    logic [TX_W-1:0] adr_aligned;

    function automatic logic [CLK_W-1:0] span(input logic [CLK_W-1:0] bits, input logic [1:0] w);
        case (w)
            W_DUAL:  return bits >> 1;
            W_QUAD:  return bits >> 2;
            default: return bits;
        endcase
    endfunction

    assign cfg_in = '{rd_mode: cfg_rd_mode, cmd_w: cfg_cmd_w, adr_w: cfg_adr_w,
                      rx_w: cfg_rx_w, adr_bytes: cfg_adr_bytes, wide_op: cfg_wide_op,
                      custom_op: cfg_custom_op, wait_code: cfg_wait,
                      setup_long: cfg_setup_long, hold_long: cfg_hold_long,
                      gap_code: cfg_gap};

    qspi_rd_opcode u_opcode (
        .rd_mode   (cfg_in.rd_mode),
        .adr_bytes (cfg_in.adr_bytes),
        .wide_op   (cfg_in.wide_op),
        .custom_op (cfg_in.custom_op),
        .opcode    (opcode)
    );

    qspi_rd_lanes u_lanes (
        .selected (!q.csn),
        .ph       (q.ph),
        .cmd_w    (q.cfg.cmd_w),
        .adr_w    (q.cfg.adr_w),
        .rx_w     (q.cfg.rx_w),
        .tx_top   (q.tx[TX_W-1 -: 4]),
        .wp_level (cfg_wp_level),
        .io_out   (io_out),
        .io_oe    (io_oe)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        has_wait = !(q.cfg.rd_mode == 3'd0 || q.cfg.rd_mode == 3'd6);
        cur_w    = (q.ph == PH_CMD) ? q.cfg.cmd_w : q.cfg.adr_w;
        rise     = half_tick && ((q.st == ST_SETUP && q.cnt == 5'd0) ||
                                 (q.st == ST_SHIFT && !q.sck));
        fall     = half_tick && (q.st == ST_SHIFT) && q.sck;
        adr_aligned = TX_W'(q.addr) << {~q.cfg.adr_bytes, 3'b000};

        case (q.cfg.rx_w)
            W_DUAL: begin rx_next = {q.rx[5:0], io_in[1:0]}; nbits = {1'b0, q.rxbits} + 4'd2; end
            W_QUAD: begin rx_next = {q.rx[3:0], io_in};      nbits = {1'b0, q.rxbits} + 4'd4; end
            default: begin rx_next = {q.rx[6:0], io_in[1]};  nbits = {1'b0, q.rxbits} + 4'd1; end
        endcase

        case (q.st)
            ST_IDLE: begin
                if (half_tick && req_valid) begin
                    d.cfg    = cfg_in;
                    d.addr   = req_addr;
                    d.len    = req_len;
                    d.csn    = 1'b0;
                    d.st     = ST_SETUP;
                    d.ph     = PH_CMD;
                    d.tx     = {opcode, 24'h000000};
                    d.left   = span(CLK_W'(8), cfg_in.cmd_w);
                    d.cnt    = cfg_in.setup_long ? 5'd2 : 5'd0;
                    d.rxbits = 3'd0;
                end
            end
            ST_SETUP: begin
                if (half_tick && q.cnt != 5'd0) d.cnt = q.cnt - 5'd1;
            end
            ST_HOLD: begin
                if (half_tick) begin
                    d.sck = 1'b0;
                    if (q.cnt == 5'd0) begin
                        d.csn = 1'b1;
                        d.st  = ST_GAP;
                        d.cnt = {q.cfg.gap_code, 1'b0};
                    end else begin
                        d.cnt = q.cnt - 5'd1;
                    end
                end
            end
            ST_GAP: begin
                if (half_tick) begin
                    if (q.cnt == 5'd0) d.st = ST_IDLE;
                    else               d.cnt = q.cnt - 5'd1;
                end
            end
            default: ;
        endcase

        if (rise) begin
            d.sck = 1'b1;
            d.st  = ST_SHIFT;
            if (q.ph == PH_RX) begin
                if (nbits == 4'd8) begin
                    d.rdata  = rx_next;
                    d.rvalid = 1'b1;
                    d.rxbits = 3'd0;
                end else begin
                    d.rxbits = nbits[2:0];
                end
                d.rx = rx_next;
                if (q.left == CLK_W'(1)) begin
                    d.st  = ST_HOLD;
                    d.cnt = q.cfg.hold_long ? 5'd2 : 5'd0;
                end
            end
        end

        if (fall) begin
            d.sck = 1'b0;
            if (q.left != CLK_W'(1)) begin
                d.left = q.left - CLK_W'(1);
                case (cur_w)
                    W_DUAL:  d.tx = q.tx << 2;
                    W_QUAD:  d.tx = q.tx << 4;
                    default: d.tx = q.tx << 1;
                endcase
            end else begin
                case (q.ph)
                    PH_CMD: begin
                        d.ph   = PH_ADR;
                        d.tx   = adr_aligned;
                        d.left = span(CLK_W'({q.cfg.adr_bytes, 3'b000}) + CLK_W'(8), q.cfg.adr_w);
                    end
                    PH_ADR: begin
                        if (has_wait) begin
                            d.ph   = PH_WAIT;
                            d.left = CLK_W'(q.cfg.wait_code) + CLK_W'(3);
                        end else begin
                            d.ph   = PH_RX;
                            d.left = span(CLK_W'({q.len, 3'b000}) + CLK_W'(8), q.cfg.rx_w);
                        end
                    end
                    default: begin
                        d.ph   = PH_RX;
                        d.left = span(CLK_W'({q.len, 3'b000}) + CLK_W'(8), q.cfg.rx_w);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE) && half_tick;
    assign cs_n      = q.csn;
    assign sck       = q.sck;
    assign rd_data   = q.rdata;
    assign rd_valid  = q.rvalid;

    assert_sck_low_desel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !sck));
    assert_sck_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(sck));
    assert_csn_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(cs_n));
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_quad_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && q.st == ST_SHIFT && q.ph == PH_RX && q.cfg.rx_w == W_QUAD) |-> (io_oe == 4'b0000));
endmodule

// File: tb/test_qspi_read_seq.sv
`timescale 1ns/1ps
module test_qspi_read_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_tick;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  cfg_rd_mode = '0;
    logic [1:0]  cfg_cmd_w = '0, cfg_adr_w = '0, cfg_rx_w = '0, cfg_adr_bytes = '0;
    logic        cfg_wide_op = 1'b0;
    logic [7:0]  cfg_custom_op = '0;
    logic [3:0]  cfg_wait = '0, cfg_gap = '0;
    logic        cfg_setup_long = 1'b0, cfg_hold_long = 1'b0, cfg_wp_level = 1'b1;
    logic        cs_n, sck, rd_valid;
    logic [3:0]  io_out, io_oe, io_in;
    logic [7:0]  rd_data;

    int checks = 0;
    int failures = 0;

    logic [7:0] q_edge[$];
    string      q_tag[$];
    logic [7:0] q_byte[$];

    int hdr = 1000, rxL = 1, exp_total = 0;
    int exp_setup = 1, exp_hold = 1, cur_gap = 2, prev_gap = 2;
    int rise_cnt = 0;
    bit started = 0, have_prev = 0, first_rise = 0;
    longint t_fall = 0, t_last_rise = 0, t_csrise = 0;

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) half_tick <= 1'b0;
        else        half_tick <= ~half_tick;

    qspi_read_seq #(.ADDR_W(32), .LEN_W(8)) i_qspi_read_seq (
        .clk, .rst_n, .half_tick, .req_valid, .req_ready, .req_addr, .req_len,
        .cfg_rd_mode, .cfg_cmd_w, .cfg_adr_w, .cfg_rx_w, .cfg_adr_bytes,
        .cfg_wide_op, .cfg_custom_op, .cfg_wait, .cfg_setup_long, .cfg_hold_long,
        .cfg_gap, .cfg_wp_level, .cs_n, .sck, .io_out, .io_oe, .io_in,
        .rd_data, .rd_valid
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 58);
    endfunction

    function automatic int lanes(input int code);
        return (code == 1) ? 2 : (code == 2) ? 4 : 1;
    endfunction

    function automatic logic [7:0] exp_op(input int mode, input int ab, input int wide, input logic [7:0] cop);
        bit w4 = (ab == 3) && (wide != 0);
        case (mode)
            0: return w4 ? 8'h13 : 8'h03;
            1: return w4 ? 8'h0C : 8'h0B;
            2: return w4 ? 8'h3C : 8'h3B;
            3: return w4 ? 8'hBC : 8'hBB;
            4: return w4 ? 8'h6C : 8'h6B;
            5: return w4 ? 8'hEC : 8'hEB;
            default: return cop;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model: data unit for the current rising-edge count
    always @* begin : flash_drv
        int j;
        int bp;
        logic [7:0] v;
        j = rise_cnt - hdr;
        io_in = 4'h0;
        if (j >= 0) begin
            bp = j * rxL;
            v = pat(bp / 8) << (bp % 8);
            case (rxL)
                1: io_in = {2'b00, v[7], 1'b0};
                2: io_in = {2'b00, v[7:6]};
                default: io_in = v[7:4];
            endcase
        end
    end

    // timing monitors
    always @(negedge cs_n) begin
        if (started) begin
            if (have_prev) chk(($time - t_csrise) == longint'(prev_gap * 8), "R9", $time - t_csrise, prev_gap * 8);
            t_fall = $time;
            first_rise = 1;
            rise_cnt = 0;
        end
    end

    always @(posedge sck) begin
        if (first_rise) begin
            chk(($time - t_fall) == longint'(exp_setup * 8), "R7", $time - t_fall, exp_setup * 8);
            first_rise = 0;
        end else begin
            chk(($time - t_last_rise) == 64'd16, "R12", $time - t_last_rise, 16);
        end
        t_last_rise = $time;
        rise_cnt = rise_cnt + 1;
    end

    always @(posedge cs_n) begin
        if (started) begin
            chk(($time - t_last_rise) == longint'(exp_hold * 8), "R8", $time - t_last_rise, exp_hold * 8);
            chk(rise_cnt == exp_total, "R5", rise_cnt, exp_total);
            prev_gap = cur_gap;
            t_csrise = $time;
            have_prev = 1;
        end
    end

    // scoreboard: lane pattern at each rising edge
    always @(posedge sck) begin
        logic [7:0] e;
        string tg;
        #1;
        if (q_edge.size() == 0) begin
            chk(0, "R12", {io_oe, io_out}, 0);
        end else begin
            e  = q_edge.pop_front();
            tg = q_tag.pop_front();
            chk((io_oe == e[7:4]) && (((io_out ^ e[3:0]) & e[7:4]) == 4'h0), tg, {io_oe, io_out}, e);
        end
    end

    // scoreboard: received bytes
    always @(negedge clk) begin
        logic [7:0] b;
        if (rst_n && rd_valid) begin
            if (q_byte.size() == 0) chk(0, "R6", rd_data, 0);
            else begin
                b = q_byte.pop_front();
                chk(rd_data == b, "R6", rd_data, b);
            end
        end
    end

    task automatic push_vec(input logic [31:0] v, input int n, input int L, input logic wp, input string tg);
        for (int i = 0; i < n; i++) begin
            logic [31:0] t;
            t = v << (L * i);
            case (L)
                1: q_edge.push_back({4'b1101, 1'b1, wp, 1'b0, t[31]});
                2: q_edge.push_back({4'b1111, 1'b1, wp, t[31:30]});
                default: q_edge.push_back({4'b1111, t[31:28]});
            endcase
            q_tag.push_back(tg);
        end
    endtask

    task automatic push_idle(input int n, input int L, input logic wp, input string tg);
        for (int i = 0; i < n; i++) begin
            if (L == 4) q_edge.push_back(8'h00);
            else        q_edge.push_back({4'b1100, 1'b1, wp, 2'b00});
            q_tag.push_back(tg);
        end
    endtask

    task automatic xfer(input int mode, input int cw, input int aw, input int rw, input int ab,
                        input int wide, input logic [7:0] cop, input int wc, input int sl,
                        input int hl, input int gc, input logic wp, input logic [31:0] addr,
                        input int len);
        int Lc, La, Lr, nd, nrx;
        logic [7:0] op;
        string itag;
        Lc = lanes(cw); La = lanes(aw); Lr = lanes(rw);
        op = exp_op(mode, ab, wide, cop);
        itag = (ab == 3 && wide != 0 && mode < 6) ? "R2 R3" : "R1 R3";
        nd = (mode == 0 || mode == 6) ? 0 : wc + 3;
        nrx = (len + 1) * 8 / Lr;
        push_vec({op, 24'h0}, 8 / Lc, Lc, wp, itag);
        push_vec(addr << (8 * (3 - ab)), (ab + 1) * 8 / La, La, wp, "R4 R3");
        push_idle(nd, Lr, wp, "R5");
        push_idle(nrx, Lr, wp, "R10");
        for (int i = 0; i <= len; i++) q_byte.push_back(pat(i));
        cfg_rd_mode = 3'(mode); cfg_cmd_w = 2'(cw); cfg_adr_w = 2'(aw); cfg_rx_w = 2'(rw);
        cfg_adr_bytes = 2'(ab); cfg_wide_op = (wide != 0); cfg_custom_op = cop;
        cfg_wait = 4'(wc); cfg_setup_long = (sl != 0); cfg_hold_long = (hl != 0);
        cfg_gap = 4'(gc); cfg_wp_level = wp;
        req_addr = addr; req_len = 8'(len);
        hdr = 8 / Lc + (ab + 1) * 8 / La + nd;
        rxL = Lr;
        exp_total = hdr + nrx;
        exp_setup = sl ? 3 : 1;
        exp_hold = hl ? 3 : 1;
        cur_gap = 2 * (gc + 1);
        started = 1;
        @(negedge clk);
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) begin
                @(posedge clk);
                break;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(cs_n == 1'b0, "R11", cs_n, 0);
        @(posedge cs_n);
        #1;
    endtask

    initial begin : watchdog
        #400000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 and R10: reset and idle pin state
        chk(cs_n == 1'b1, "R11", cs_n, 1);
        chk(sck == 1'b0, "R11", sck, 0);
        chk(rd_valid == 1'b0, "R11", rd_valid, 0);
        chk(io_oe == 4'b1101, "R10", io_oe, 4'b1101);
        chk(io_out[3:2] == 2'b11 && io_out[0] == 1'b0, "R10", io_out, 4'b1100);
        cfg_wp_level = 1'b0;
        #1;
        chk(io_out[2] == 1'b0, "R10", io_out, 4'b1000);

        //   mode cw aw rw ab wide cop   wc sl hl gc wp addr            len
        xfer(0,   0, 0, 0, 2, 0, 8'h00,  5, 0, 0, 0, 1, 32'h00123456,   2);
        xfer(1,   0, 0, 0, 3, 1, 8'h00,  0, 1, 1, 5, 0, 32'h89ABCDEF,   1);
        xfer(3,   0, 1, 1, 2, 0, 8'h00,  4, 0, 1, 2, 0, 32'h00A1B2C3,   3);
        xfer(5,   0, 2, 2, 3, 0, 8'h00, 15, 1, 0, 15, 1, 32'hFEDCBA98,  4);
        xfer(7,   2, 1, 0, 1, 0, 8'h5A,  2, 1, 1, 1, 1, 32'h0000BEEF,   1);
        xfer(6,   1, 0, 2, 0, 1, 8'hC3,  7, 0, 0, 3, 0, 32'h00000077,   2);
        xfer(4,   0, 0, 2, 3, 1, 8'h00,  1, 0, 0, 0, 1, 32'h01020304,   3);
        xfer(2,   0, 0, 1, 2, 0, 8'h00,  0, 1, 0, 0, 0, 32'h00ABCDEF,   0);
        xfer(5,   0, 2, 2, 3, 1, 8'h00,  3, 0, 1, 4, 1, 32'h10203040,   7);

        repeat (20) @(negedge clk);
        chk(q_edge.size() == 0, "R5", q_edge.size(), 0);
        chk(q_byte.size() == 0, "R6", q_byte.size(), 0);
        chk(cs_n == 1'b1 && sck == 1'b0, "R11", {cs_n, sck}, 2'b10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule